// File: doc/BRIEF.md
# MII to RMII Transmit Converter

This block sits between an Ethernet MAC's 4-bit media-independent transmit port and a reduced-pin PHY's 2-bit transmit port. The MAC presents one nibble and an enable on each MII clock. The block turns each nibble into two dibits, least significant pair first, on the reference clock. The MII clock runs at half the reference rate and is derived from it, so the two clocks keep a fixed phase. The enable toward the PHY covers exactly the cycles that carry valid dibits. Preamble, delimiter and payload pass through bit for bit. The block adds no framing and no checking.

A static speed parameter picks the rate. In fast mode each dibit lasts one reference cycle. In slow mode the MAC holds each nibble for ten MII cycles, and each dibit lasts ten reference cycles. In that mode the MII-side sampler re-aligns its ten-cycle slot counter to the rising edge of the MAC enable. A second static parameter feeds the transmit dibit and enable back into the block's receive-side outputs in place of the PHY's receive inputs, for diagnostics.

The reference-side controller has three states. IDLE holds the enable low and the data at 00. It moves to LOW_PAIR when a fresh nibble arrives with its enable set. LOW_PAIR drives bits [1:0] for one dibit span and then moves to HIGH_PAIR. HIGH_PAIR drives bits [3:2] until the next fresh nibble arrives. It moves to LOW_PAIR if that nibble is enabled, and back to IDLE if it is not.

Top module: `mii2rmii_tx`

## Requirements
- R1: In fast mode (SPEED_100=1) each enabled nibble appears on `rmii_txd` as two dibits on consecutive reference cycles: bits [1:0] first, then bits [3:2].
- R2: In slow mode (SPEED_100=0) the nibble is sampled once every 10 MII cycles, counting from the MII cycle where `mii_txen` rises. Each of its two dibits is held for 10 reference cycles, with bits [1:0] first.
- R3: `rmii_txen` rises in the same cycle as the first dibit of a frame's first nibble. It falls right after the high dibit of the frame's last nibble. A frame of N nibbles keeps it high for exactly 2·N·span cycles, where span is 1 in fast mode and 10 in slow mode.
- R4: Whenever `rmii_txen` is low, `rmii_txd` is 00.
- R5: While `rst_n` is low, `rmii_txen` is 0 and `rmii_txd` is 00.
- R6: With LOOPBACK=1, `rx_dibit` equals `rmii_txd` and `rx_crsdv` equals `rmii_txen` in every cycle, and the PHY receive inputs have no effect on these outputs.
- R7: With LOOPBACK=0, `rx_dibit` equals `phy_rxd` and `rx_crsdv` equals `phy_crsdv`.
- R8: Two frames separated by a single idle MII slot are both delivered complete, with `rmii_txen` dropping for the gap. Nibble values, including 0 and F, are not altered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mii_clk | input | 1 | MII transmit clock, half the reference rate and derived from it |
| ref_clk | input | 1 | RMII reference clock |
| rst_n | input | 1 | Asynchronous reset, active low, for both domains |
| mii_txd | input | 4 | Nibble from the MAC |
| mii_txen | input | 1 | MAC transmit enable |
| rmii_txd | output | 2 | Dibit toward the PHY |
| rmii_txen | output | 1 | Transmit enable toward the PHY |
| phy_rxd | input | 2 | Receive dibit from the PHY |
| phy_crsdv | input | 1 | Carrier/data-valid from the PHY |
| rx_dibit | output | 2 | Receive dibit to the receive path (loopback-selected) |
| rx_crsdv | output | 1 | Carrier/data-valid to the receive path (loopback-selected) |

## Verification
A frame can end and a new one begin in the same controller step. The HIGH_PAIR state must decide, in that step, between returning to IDLE and loading the next nibble. The bench provokes this with two frames separated by a single idle MII slot. A scoreboard holds the dibits expected for each enabled nibble. It must see the high dibit of the last nibble, then exactly the idle cycles with 00, then the new frame's low dibit. It must see no extra or missing enable cycle. In loopback, the same cycles also check that the receive-side outputs follow the transmit outputs.

// File: rtl/mii2rmii_pkg.sv
package mii2rmii_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_LOW_PAIR  = 2'd1,
        ST_HIGH_PAIR = 2'd2
    } ser_state_t;

    // reference cycles that one dibit occupies
    function automatic int dibit_span(input bit fast);
        return fast ? 1 : 10;
    endfunction

endpackage

// File: rtl/mii_nibble_capture.sv
module mii_nibble_capture #(
    parameter int SPAN = 1,
    parameter int NW   = 4
) (
    input  logic          mii_clk,
    input  logic          rst_n,
    input  logic [NW-1:0] nib_in,
    input  logic          en_in,
    output logic [NW-1:0] hold_nib,
    output logic          hold_en,
    output logic          hold_tog
);
    localparam int CW = $clog2(SPAN + 1);

    logic [CW-1:0] slot_cnt;
    logic          en_prev;
    logic          en_rise;
    logic          take;

    always_comb begin
        en_rise = en_in & ~en_prev;
        take    = en_rise | (slot_cnt == '0);
    end

    always_ff @(posedge mii_clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_cnt <= '0;
            en_prev  <= 1'b0;
            hold_nib <= '0;
            hold_en  <= 1'b0;
            hold_tog <= 1'b0;
        end else begin
            en_prev <= en_in;
            if (take) begin
                hold_nib <= nib_in;
                hold_en  <= en_in;
                hold_tog <= ~hold_tog;
            end
            if (SPAN == 1) begin
                slot_cnt <= '0;
            end else if (en_rise) begin
                slot_cnt <= CW'(1);
            end else if (slot_cnt == CW'(SPAN - 1)) begin
                slot_cnt <= '0;
            end else begin
                slot_cnt <= slot_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fresh_detect.sv
module fresh_detect (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic fresh
);
    logic tog_seen;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) tog_seen <= 1'b0;
        else        tog_seen <= tog_in;
    end

    // the toggle is sampled at a fixed phase of the derived clock
    always_comb fresh = tog_in ^ tog_seen;
endmodule

// File: rtl/dibit_serializer.sv
module dibit_serializer
    import mii2rmii_pkg::*;
#(
    parameter int SPAN = 1,
    parameter int NW   = 4
) (
    input  logic          ref_clk,
    input  logic          rst_n,
    input  logic          fresh,
    input  logic [NW-1:0] hold_nib,
    input  logic          hold_en,
    output logic [1:0]    txd,
    output logic          txen
);
    localparam int PW = $clog2(SPAN + 1);

    ser_state_t    state;
    logic [PW-1:0] phase;
    logic [NW-1:0] nib;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            phase <= '0;
            nib   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (fresh && hold_en) begin
                        state <= ST_LOW_PAIR;
                        nib   <= hold_nib;
                        phase <= '0;
                    end
                end
                ST_LOW_PAIR: begin
                    if (phase == PW'(SPAN - 1)) begin
                        state <= ST_HIGH_PAIR;
                        phase <= '0;
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                ST_HIGH_PAIR: begin
                    if (fresh) begin
                        if (hold_en) begin
                            state <= ST_LOW_PAIR;
                            nib   <= hold_nib;
                            phase <= '0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_LOW_PAIR:  begin txen = 1'b1; txd = nib[1:0]; end
            ST_HIGH_PAIR: begin txen = 1'b1; txd = nib[3:2]; end
            default:      begin txen = 1'b0; txd = 2'b00;    end
        endcase
    end
endmodule

// File: rtl/rx_return_path.sv
module rx_return_path #(
    parameter bit LOOPBACK = 1'b0
) (
    input  logic [1:0] tx_dibit,
    input  logic       tx_en,
    input  logic [1:0] phy_dibit,
    input  logic       phy_dv,
    output logic [1:0] rx_dibit,
    output logic       rx_dv
);
    generate
        if (LOOPBACK) begin : g_loop
            always_comb begin
                rx_dibit = tx_dibit;
                rx_dv    = tx_en;
            end
        end else begin : g_pass
            always_comb begin
                rx_dibit = phy_dibit;
                rx_dv    = phy_dv;
            end
        end
    endgenerate
endmodule

// File: rtl/mii2rmii_tx.sv
module mii2rmii_tx
    import mii2rmii_pkg::*;
#(
    parameter bit SPEED_100 = 1'b1,
    parameter bit LOOPBACK  = 1'b0
) (
    input  logic       mii_clk,
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic [3:0] mii_txd,
    input  logic       mii_txen,
    output logic [1:0] rmii_txd,
    output logic       rmii_txen,
    input  logic [1:0] phy_rxd,
    input  logic       phy_crsdv,
    output logic [1:0] rx_dibit,
    output logic       rx_crsdv
);
    localparam int SPAN = dibit_span(SPEED_100);
    localparam int NW   = 4;

    logic [NW-1:0] hold_nib;
    logic          hold_en;
    logic          hold_tog;
    logic          fresh;

    mii_nibble_capture #(.SPAN(SPAN), .NW(NW)) u_cap (
        .mii_clk (mii_clk),
        .rst_n   (rst_n),
        .nib_in  (mii_txd),
        .en_in   (mii_txen),
        .hold_nib(hold_nib),
        .hold_en (hold_en),
        .hold_tog(hold_tog)
    );

    fresh_detect u_fresh (
        .ref_clk(ref_clk),
        .rst_n  (rst_n),
        .tog_in (hold_tog),
        .fresh  (fresh)
    );

    dibit_serializer #(.SPAN(SPAN), .NW(NW)) u_ser (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .fresh   (fresh),
        .hold_nib(hold_nib),
        .hold_en (hold_en),
        .txd     (rmii_txd),
        .txen    (rmii_txen)
    );

    rx_return_path #(.LOOPBACK(LOOPBACK)) u_ret (
        .tx_dibit (rmii_txd),
        .tx_en    (rmii_txen),
        .phy_dibit(phy_rxd),
        .phy_dv   (phy_crsdv),
        .rx_dibit (rx_dibit),
        .rx_dv    (rx_crsdv)
    );
endmodule

// File: rtl/mii2rmii_tx_chk.sv
module mii2rmii_tx_chk #(
    parameter bit SPEED_100 = 1'b1,
    parameter bit LOOPBACK  = 1'b0
) (
    input logic       ref_clk,
    input logic       rst_n,
    input logic [1:0] rmii_txd,
    input logic       rmii_txen,
    input logic [1:0] phy_rxd,
    input logic       phy_crsdv,
    input logic [1:0] rx_dibit,
    input logic       rx_crsdv
);
    localparam int SPAN = SPEED_100 ? 1 : 10;
    localparam int PER  = 2 * SPAN;

    // cycles the enable has been high before the current sample
    int unsigned run;
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n)         run <= 0;
        else if (rmii_txen) run <= run + 1;
        else                run <= 0;
    end

    // R4: quiet data while not enabled
    p_idle_quiet_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !rmii_txen |-> rmii_txd == 2'b00);

    // R3: a burst never lasts a single cycle
    p_rise_holds_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(rmii_txen) |=> rmii_txen);

    // R3: burst length is a whole number of nibbles
    p_whole_nibbles_r3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!rmii_txen && run != 0) |-> (run % PER) == 0);

    // R2: the dibit changes only on a span boundary inside a burst
    p_dibit_hold_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (rmii_txen && run != 0 && (run % SPAN) != 0) |-> $stable(rmii_txd));

    generate
        if (LOOPBACK) begin : g_lb
            // R6
            p_loop_follow_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
                rx_dibit == rmii_txd && rx_crsdv == rmii_txen);
        end else begin : g_ps
            // R7
            p_pass_follow_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
                rx_dibit == phy_rxd && rx_crsdv == phy_crsdv);
        end
    endgenerate
endmodule

bind mii2rmii_tx mii2rmii_tx_chk #(.SPEED_100(SPEED_100), .LOOPBACK(LOOPBACK)) u_chk (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .rmii_txd (rmii_txd),
    .rmii_txen(rmii_txen),
    .phy_rxd  (phy_rxd),
    .phy_crsdv(phy_crsdv),
    .rx_dibit (rx_dibit),
    .rx_crsdv (rx_crsdv)
);

// File: tb/mii2rmii_tx_test.sv
module mii2rmii_tx_test;
    logic ref_clk = 1'b0;
    logic mii_clk = 1'b0;
    logic rst_n   = 1'b0;

    always #5 ref_clk = ~ref_clk;
    always @(posedge ref_clk) begin
        #1;
        mii_clk = ~mii_clk;
    end

    // fast instance with loopback
    logic [3:0] f_txd = '0;
    logic       f_txen = 1'b0;
    logic [1:0] f_rmii_txd, f_rx_dibit;
    logic       f_rmii_txen, f_rx_crsdv;
    logic [1:0] f_phy_rxd = 2'b11;
    logic       f_phy_dv  = 1'b1;

    // slow instance, pass-through receive
    logic [3:0] s_txd = '0;
    logic       s_txen = 1'b0;
    logic [1:0] s_rmii_txd, s_rx_dibit;
    logic       s_rmii_txen, s_rx_crsdv;
    logic [1:0] s_phy_rxd = 2'b00;
    logic       s_phy_dv  = 1'b0;

    mii2rmii_tx #(.SPEED_100(1'b1), .LOOPBACK(1'b1)) uut (
        .mii_clk(mii_clk), .ref_clk(ref_clk), .rst_n(rst_n),
        .mii_txd(f_txd), .mii_txen(f_txen),
        .rmii_txd(f_rmii_txd), .rmii_txen(f_rmii_txen),
        .phy_rxd(f_phy_rxd), .phy_crsdv(f_phy_dv),
        .rx_dibit(f_rx_dibit), .rx_crsdv(f_rx_crsdv)
    );

    mii2rmii_tx #(.SPEED_100(1'b0), .LOOPBACK(1'b0)) uut_slow (
        .mii_clk(mii_clk), .ref_clk(ref_clk), .rst_n(rst_n),
        .mii_txd(s_txd), .mii_txen(s_txen),
        .rmii_txd(s_rmii_txd), .rmii_txen(s_rmii_txen),
        .phy_rxd(s_phy_rxd), .phy_crsdv(s_phy_dv),
        .rx_dibit(s_rx_dibit), .rx_crsdv(s_rx_crsdv)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [1:0] q_fast[$];
    logic [1:0] q_slow[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // PHY receive inputs move away from sampling edges
    always @(posedge ref_clk) begin
        #2;
        s_phy_rxd = s_phy_rxd + 2'd1;
        s_phy_dv  = ~s_phy_dv;
        f_phy_rxd = ~f_phy_rxd;
    end

    // monitors
    always @(negedge ref_clk) begin
        if (rst_n && !done) begin
            if (f_rmii_txen) begin
                if (q_fast.size() == 0) chk(1'b0, "R3 fast enable without data", 1, 0);
                else begin
                    logic [1:0] e;
                    e = q_fast.pop_front();
                    chk(f_rmii_txd == e, "R1/R8 fast dibit", f_rmii_txd, e);
                end
            end else begin
                chk(f_rmii_txd == 2'b00, "R4 fast idle data", f_rmii_txd, 0);
            end
            chk(f_rx_dibit == f_rmii_txd, "R6 loop dibit", f_rx_dibit, f_rmii_txd);
            chk(f_rx_crsdv == f_rmii_txen, "R6 loop enable", f_rx_crsdv, f_rmii_txen);

            if (s_rmii_txen) begin
                if (q_slow.size() == 0) chk(1'b0, "R3 slow enable without data", 1, 0);
                else begin
                    logic [1:0] e;
                    e = q_slow.pop_front();
                    chk(s_rmii_txd == e, "R2 slow dibit", s_rmii_txd, e);
                end
            end else begin
                chk(s_rmii_txd == 2'b00, "R4 slow idle data", s_rmii_txd, 0);
            end
            chk(s_rx_dibit == s_phy_rxd, "R7 pass dibit", s_rx_dibit, s_phy_rxd);
            chk(s_rx_crsdv == s_phy_dv, "R7 pass valid", s_rx_crsdv, s_phy_dv);
        end
    end

    task automatic fast_frame(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            logic [3:0] v;
            @(negedge mii_clk);
            v = (i == 0) ? 4'h0 : (i == n - 1) ? 4'hF : 4'((seed + i * 7) & 15);
            f_txd  = v;
            f_txen = 1'b1;
            q_fast.push_back(v[1:0]);
            q_fast.push_back(v[3:2]);
        end
    endtask

    task automatic fast_gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge mii_clk);
            f_txen = 1'b0;
            f_txd  = 4'hA;
        end
    endtask

    task automatic slow_frame(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            logic [3:0] v;
            v = 4'((seed + i * 5) & 15);
            for (int k = 0; k < 10; k++) q_slow.push_back(v[1:0]);
            for (int k = 0; k < 10; k++) q_slow.push_back(v[3:2]);
            for (int c = 0; c < 10; c++) begin
                @(negedge mii_clk);
                s_txd  = v;
                s_txen = 1'b1;
            end
        end
    endtask

    task automatic slow_gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge mii_clk);
            s_txen = 1'b0;
            s_txd  = 4'h6;
        end
    endtask

    initial begin
        repeat (4) @(negedge ref_clk);
        // R5: reset state
        chk(f_rmii_txen == 1'b0, "R5 fast enable in reset", f_rmii_txen, 0);
        chk(f_rmii_txd == 2'b00, "R5 fast data in reset", f_rmii_txd, 0);
        chk(s_rmii_txen == 1'b0, "R5 slow enable in reset", s_rmii_txen, 0);
        chk(s_rmii_txd == 2'b00, "R5 slow data in reset", s_rmii_txd, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge ref_clk);

        fork
            begin
                fast_frame(8, 5);   // R1 preamble-like start
                fast_gap(3);
                fast_frame(1, 9);   // R3 single nibble
                fast_gap(1);        // R8 one idle slot
                fast_frame(6, 2);
                fast_gap(1);
                fast_frame(4, 11);
                fast_gap(4);
            end
            begin
                slow_frame(3, 1);   // R2
                slow_gap(15);
                slow_frame(2, 12);
                slow_gap(12);
            end
        join

        repeat (60) @(negedge ref_clk);
        // R3: every expected dibit consumed, enables low
        chk(q_fast.size() == 0, "R3 fast leftover dibits", q_fast.size(), 0);
        chk(q_slow.size() == 0, "R3 slow leftover dibits", q_slow.size(), 0);
        chk(f_rmii_txen == 1'b0, "R3 fast enable after frames", f_rmii_txen, 0);
        chk(s_rmii_txen == 1'b0, "R3 slow enable after frames", s_rmii_txen, 0);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule